// File: doc/BRIEF.md
# Gated IF Frequency Counter with Multiplexed Status Output

This block measures the frequency of an already-squared intermediate-frequency signal by counting its rising edges over a gate window timed from the reference clock. At the end of the window the count is compared with a programmed acceptance range, and the verdict is driven onto a single status output.

The same output carries an external station-detect signal whenever counting is disabled. Software raises the enable bit to start one measurement. The status output then stays low for the whole window and reports in-range (high) or out-of-range (low) once the window closes. Lowering the enable bit clears the counter and returns the output to the station-detect pass-through.

A gate-select bit picks the short or the long window. The windows are 32 and 64 prescaled ticks. The prescale is a parameter, so the window can be scaled to any reference clock.

Top module: `if_gate_counter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `do_o` is 0 and the block is idle.
- R2: While `ct` is 0, `do_o` equals the value `sd_in` had one clock earlier.
- R3: From the clock edge that first samples `ct`=1, `do_o` is 0 for the whole gate window, whatever `sd_in` and `if_in` do.
- R4: The gate window lasts PRESCALE*32 reference cycles when `gt`=0 and PRESCALE*64 cycles when `gt`=1. `gt` is sampled on the edge that starts the measurement. The verdict appears on `do_o` after the edge exactly one window length after the start edge.
- R5: The counter counts rising edges of `if_in` after a two-flop synchroniser. Only edges that reach the counter inside the window are counted. The count saturates at all ones instead of wrapping.
- R6: The verdict is 1 when `lo_lim` <= count <= `hi_lim`, with both bounds inclusive, and 0 otherwise. When `lo_lim` > `hi_lim`, the verdict is always 0.
- R7: After the window closes, `do_o` holds the verdict for as long as `ct` stays 1. Changes on `sd_in` and `if_in` do not affect it, and no new measurement starts.
- R8: Driving `ct` to 0 at any time, including mid-window, clears the counter and aborts any measurement. The station-detect pass-through returns on the next edge. A new measurement needs `ct` to go to 0 and then back to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_in | input | 1 | Squared IF signal, asynchronous |
| sd_in | input | 1 | Station-detect input, passed through while disabled |
| ct | input | 1 | Measurement enable; 1 starts, 0 clears |
| gt | input | 1 | Gate select: 0 short window, 1 long window |
| lo_lim | input | CNT_W | Lower bound of the acceptance range (inclusive) |
| hi_lim | input | CNT_W | Upper bound of the acceptance range (inclusive) |
| do_o | output | 1 | Status: station-detect, busy-low, or verdict |

## Verification
The assertions check on every cycle that the output is low while a measurement runs and that it tracks station-detect with one cycle of delay while idle. They also check that a low enable forces the idle state, that a finished verdict holds while the enable stays high, that the gate tick count never passes its target, and that the edge count never wraps. Only the bench scenarios can show the exact window length for each gate setting and the exact number of edges counted. The same holds for the inclusive bound handling, for edges that fall outside a short window but inside a long one, and for re-arming after the enable drops.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_DONE = 2'd2
    } meas_state_e;
endpackage

// File: rtl/ifc_in_sync.sv
// Multi-flop synchroniser with a rising-edge detector on its output.
module ifc_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-1:0], sig_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    assign rise_o = s_q.chain[STAGES-1] & ~s_q.chain[STAGES];
endmodule

// File: rtl/ifc_gate_timer.sv
// Prescaled gate window timer: expires after PRESCALE*ticks run cycles.
module ifc_gate_timer #(
    parameter int PRESCALE    = 1000,
    parameter int SHORT_TICKS = 32,
    parameter int LONG_TICKS  = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic long_i,
    output logic expire_o
);
    localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int TICK_W = $clog2(LONG_TICKS + 1);
    localparam logic [PRE_W-1:0]  PRE_LAST   = PRE_W'(PRESCALE - 1);
    localparam logic [TICK_W-1:0] SHORT_LAST = TICK_W'(SHORT_TICKS - 1);
    localparam logic [TICK_W-1:0] LONG_LAST  = TICK_W'(LONG_TICKS - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [TICK_W-1:0] ticks;
        logic              long_sel;
    } timer_t;

    timer_t t_d, t_q;
    logic [TICK_W-1:0] last_tick;
    logic              pre_wrap;

    always_comb begin
        last_tick = t_q.long_sel ? LONG_LAST : SHORT_LAST;
        pre_wrap  = (t_q.pre == PRE_LAST);
        t_d       = t_q;
        if (clear_i) begin
            t_d.pre      = '0;
            t_d.ticks    = '0;
            t_d.long_sel = long_i;
        end else if (run_i) begin
            if (pre_wrap) begin
                t_d.pre = '0;
                if (t_q.ticks != last_tick) t_d.ticks = t_q.ticks + 1'b1;
            end else begin
                t_d.pre = t_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign expire_o = run_i & pre_wrap & (t_q.ticks == last_tick);

    // R4
    tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.ticks <= (t_q.long_sel ? LONG_LAST : SHORT_LAST));

    // R4
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.pre <= PRE_LAST);
endmodule

// File: rtl/ifc_edge_counter.sv
// Saturating edge counter with synchronous clear.
module ifc_edge_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cnt_next_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clear_i)                         c_d.cnt = '0;
        else if (inc_i && (c_q.cnt != '1))   c_d.cnt = c_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_o      = c_q.cnt;
    assign cnt_next_o = c_d.cnt;

    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && cnt_o == '1) |=> (cnt_o == '1));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/ifc_status_fsm.sv
// Measurement sequencer and status output multiplexer.
module ifc_status_fsm
    import ifc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ct_i,
    input  logic             sd_i,
    input  logic             expire_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] lo_i,
    input  logic [CNT_W-1:0] hi_i,
    output logic             clear_o,
    output logic             run_o,
    output logic             do_o
);
    typedef struct packed {
        meas_state_e st;
        logic        dout;
    } fsm_t;

    fsm_t r_d, r_q;
    logic in_range;

    always_comb begin
        in_range = (count_i >= lo_i) && (count_i <= hi_i);
        r_d      = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (ct_i) begin
                    r_d.st   = ST_MEAS;
                    r_d.dout = 1'b0;
                end else begin
                    r_d.dout = sd_i;
                end
            end
            ST_MEAS: begin
                if (!ct_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.dout = sd_i;
                end else if (expire_i) begin
                    r_d.st   = ST_DONE;
                    r_d.dout = in_range;
                end else begin
                    r_d.dout = 1'b0;
                end
            end
            ST_DONE: begin
                if (!ct_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.dout = sd_i;
                end
            end
            default: begin
                r_d.st   = ST_IDLE;
                r_d.dout = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.dout <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign clear_o = (r_q.st == ST_IDLE);
    assign run_o   = (r_q.st == ST_MEAS);
    assign do_o    = r_q.dout;

    // R3
    meas_do_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_MEAS) |-> !do_o);

    // R2
    idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && r_q.st == ST_IDLE) |-> (do_o == $past(sd_i)));

    // R8
    ct_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ct_i |=> (r_q.st == ST_IDLE));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_DONE && ct_i) |=> (r_q.st == ST_DONE && $stable(do_o)));
endmodule

// File: rtl/if_gate_counter.sv
// Top: gated IF edge counter with range verdict and multiplexed status pin.
module if_gate_counter #(
    parameter int CNT_W       = 16,
    parameter int PRESCALE    = 1000,
    parameter int SHORT_TICKS = 32,
    parameter int LONG_TICKS  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             if_in,
    input  logic             sd_in,
    input  logic             ct,
    input  logic             gt,
    input  logic [CNT_W-1:0] lo_lim,
    input  logic [CNT_W-1:0] hi_lim,
    output logic             do_o
);
    logic             if_rise;
    logic             gate_expire;
    logic             seq_clear;
    logic             seq_run;
    logic [CNT_W-1:0] edge_cnt;
    logic [CNT_W-1:0] edge_cnt_next;

    ifc_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (if_in),
        .rise_o (if_rise)
    );

    ifc_gate_timer #(
        .PRESCALE    (PRESCALE),
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (seq_clear),
        .run_i    (seq_run),
        .long_i   (gt),
        .expire_o (gate_expire)
    );

    ifc_edge_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (seq_clear),
        .inc_i      (seq_run & if_rise),
        .cnt_o      (edge_cnt),
        .cnt_next_o (edge_cnt_next)
    );

    ifc_status_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ct_i     (ct),
        .sd_i     (sd_in),
        .expire_i (gate_expire),
        .count_i  (edge_cnt_next),
        .lo_i     (lo_lim),
        .hi_i     (hi_lim),
        .clear_o  (seq_clear),
        .run_o    (seq_run),
        .do_o     (do_o)
    );

    // R5: edge_cnt is visible for debug probing only
    logic unused_cnt;
    assign unused_cnt = ^edge_cnt;
endmodule

// File: tb/tb_if_gate_counter.sv
module tb_if_gate_counter;
    localparam int CW  = 8;
    localparam int PS  = 4;
    localparam int G_S = PS * 32;
    localparam int G_L = PS * 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          if_in = 1'b0;
    logic          sd_in = 1'b0;
    logic          ct = 1'b0;
    logic          gt = 1'b0;
    logic [CW-1:0] lo_lim = '0;
    logic [CW-1:0] hi_lim = '0;
    logic          do_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2.5 clk = ~clk;

    if_gate_counter #(
        .CNT_W(CW), .PRESCALE(PS), .SHORT_TICKS(32), .LONG_TICKS(64), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .if_in(if_in), .sd_in(sd_in), .ct(ct), .gt(gt),
        .lo_lim(lo_lim), .hi_lim(hi_lim), .do_o(do_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_edge();
        @(posedge clk); #1;
    endtask

    // One measurement: n pulses (2 high, 2 low) starting 'start' edges after the start edge.
    task automatic measure(input string req, input int start, input int n, input bit long_g,
                           input int lo, input int hi, input int exp);
        int g     = long_g ? G_L : G_S;
        int early = 0;
        gt = long_g; lo_lim = CW'(lo); hi_lim = CW'(hi); sd_in = 1'b1;
        wait_edge();
        ct = 1'b1;
        for (int j = 0; j <= g; j++) begin
            wait_edge();
            if_in = (j >= start) && (j < start + 4 * n) && (((j - start) % 4) < 2);
            @(negedge clk);
            if (j < g && do_o !== 1'b0) early++;
            if (j == g) check({req, " verdict"}, int'(do_o), exp);
        end
        if_in = 1'b0;
        check({req, " R3 busy low"}, early, 0);
    endtask

    task automatic release_ct(input bit sdv);
        sd_in = sdv; ct = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R8 pass-through restored", int'(do_o), int'(sdv));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset do low", int'(do_o), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 first cycle after reset", int'(do_o), 0);
    endtask

    task automatic t_passthrough();
        wait_edge(); sd_in = 1'b1;
        @(negedge clk);
        check("R2 not yet", int'(do_o), 0);
        @(posedge clk); @(negedge clk);
        check("R2 follows sd high", int'(do_o), 1);
        sd_in = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2 follows sd low", int'(do_o), 0);
    endtask

    task automatic t_ranges();
        measure("R5 R6 inside", 4, 10, 1'b0, 5, 15, 1);     release_ct(1'b0);
        measure("R6 both bounds equal", 4, 10, 1'b0, 10, 10, 1); release_ct(1'b1);
        measure("R6 below lo", 4, 10, 1'b0, 11, 20, 0);      release_ct(1'b0);
        measure("R6 above hi", 4, 10, 1'b0, 0, 9, 0);        release_ct(1'b1);
        measure("R6 lo gt hi", 4, 10, 1'b0, 12, 8, 0);       release_ct(1'b0);
        measure("R5 zero edges", 4, 0, 1'b0, 0, 0, 1);       release_ct(1'b0);
    endtask

    task automatic t_gate();
        measure("R4 short gate misses late edges", 140, 10, 1'b0, 10, 10, 0); release_ct(1'b0);
        measure("R4 long gate counts late edges", 140, 10, 1'b1, 10, 10, 1);  release_ct(1'b0);
    endtask

    task automatic t_hold_rearm();
        int moved = 0;
        measure("R7 first result", 4, 10, 1'b0, 10, 10, 1);
        for (int i = 0; i < 300; i++) begin
            wait_edge();
            sd_in = i[1];
            if_in = i[0];
            @(negedge clk);
            if (do_o !== 1'b1) moved++;
        end
        if_in = 1'b0;
        check("R7 verdict held", moved, 0);
        release_ct(1'b0);
        measure("R8 rearm new result", 4, 3, 1'b0, 10, 10, 0);
        release_ct(1'b1);
    endtask

    task automatic t_abort();
        gt = 1'b0; sd_in = 1'b1;
        wait_edge(); ct = 1'b1;
        repeat (50) @(posedge clk);
        @(negedge clk);
        check("R3 low mid-window", int'(do_o), 0);
        release_ct(1'b1);
        repeat (200) @(posedge clk);
        @(negedge clk);
        check("R8 abort stays idle", int'(do_o), 1);
        // after abort, a full new measurement starts from zero
        measure("R8 after abort", 4, 5, 1'b0, 5, 5, 1);
        release_ct(1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_passthrough();
        t_ranges();
        t_gate();
        t_hold_rearm();
        t_abort();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule